// File: doc/BRIEF.md
# Sleep and Idle power-mode controller

This block decides which clock domains of a processor subsystem run. The CPU asks to save power with a one-cycle request and a one-bit mode operand. The controller then moves into one of two low-power states. In Idle only the CPU clock is gated, and peripherals keep their clock. In Sleep the main oscillator, the system and peripheral clocks and the fail-safe clock monitor all stop. The low-power RC oscillator keeps running in Sleep only while the watchdog is enabled. When Sleep is accepted with the watchdog enabled, the block clears the watchdog in the same cycle, while the clocks are still running.

Three kinds of event end a low-power state: an interrupt request whose enable bit is set, a watchdog time-out, and a device reset request. The first two keep the clock-source selection that was in force when the state was entered. A reset returns the selection to its default and returns straight to run. Leaving Sleep through an interrupt or a time-out passes first through a start-up hold, so the main oscillator can settle before the CPU clock comes back. The cause of the most recent wake is reported on a two-bit output.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every enable is high, `clk_src_o` equals `DEFAULT_SRC` and `wake_cause` is 0 (none).
- R2: A request with `ps_mode` = 1 (Idle) in the run state gates only the CPU clock from the next cycle. The peripheral clock, oscillator, RC oscillator and clock monitor enables stay high.
- R3: A request with `ps_mode` = 0 (Sleep) in the run state clears the CPU, peripheral, oscillator and monitor enables from the next cycle. `lprc_en` then follows `wdt_en`.
- R4: `wdt_clr` is high for the single cycle in which a Sleep request is accepted, and only when `wdt_en` is high. An Idle request never raises it.
- R5: A low-power state wakes when some bit is high in both `irq_pend` and `irq_en`, or when `wdt_timeout` is high. A pending interrupt that is not enabled does not wake it.
- R6: An Idle wake restores all enables on the next cycle.
- R7: A Sleep wake caused by an interrupt or a time-out enters a start-up hold that lasts `startup_cycles`+1 cycles. During the hold only `osc_en` and `lprc_en` are high. Full run follows the hold.
- R8: `src_wr` loads `src_val` into `clk_src_o` only in the run state. Writes made while the CPU clock is gated are ignored, so the source from entry is presented again on wake.
- R9: A power-save request that arrives in any state other than run has no effect.
- R10: `dev_rst` in any state returns all enables high on the next cycle, with no start-up hold, and sets `clk_src_o` to `DEFAULT_SRC`.
- R11: `wake_cause` holds the last wake: 1 = interrupt, 2 = watchdog, 3 = reset. When causes coincide, reset wins over watchdog and watchdog wins over interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_req | input | 1 | Power-save request strobe |
| ps_mode | input | 1 | Requested mode: 0 Sleep, 1 Idle |
| src_wr | input | 1 | Clock-source selection write strobe |
| src_val | input | SRC_W | New clock-source selection |
| irq_pend | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line wake enables |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out event |
| dev_rst | input | 1 | Device reset request (wakes and restores defaults) |
| startup_cycles | input | CNT_W | Oscillator start-up hold length minus one |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| clk_src_o | output | SRC_W | Active clock-source selection |
| wake_cause | output | 2 | Cause of the last wake |

## Verification
The bench tests the start-up hold for both a zero and a non-zero length. A counter that is off by one would show one hold cycle too many or too few. It writes the clock source during Sleep and expects the value from entry after wake, which catches a register that loads outside run. The bench raises the watchdog time-out, an enabled interrupt and a reset together, so that a wrong priority would report the wrong cause or pass through an unneeded hold. It also checks the watchdog clear with the watchdog disabled and with an Idle request, and sends requests while asleep to make sure the state does not move.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2,
        PM_WAKE  = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_IRQ  = 2'd1,
        WK_WDT  = 2'd2,
        WK_RST  = 2'd3
    } wake_cause_e;

    localparam logic PS_SLEEP = 1'b0;
    localparam logic PS_IDLE  = 1'b1;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic lprc;
        logic fscm;
    } gate_t;

    typedef struct packed {
        logic        hit;
        wake_cause_e cause;
    } wake_t;

    function automatic gate_t gates_for(pm_state_e st, logic wdt_on);
        gate_t g;
        case (st)
            PM_RUN:   g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, lprc: 1'b1, fscm: 1'b1};
            PM_IDLE:  g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, lprc: 1'b1, fscm: 1'b1};
            PM_SLEEP: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, lprc: wdt_on, fscm: 1'b0};
            default:  g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, lprc: 1'b1, fscm: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pmc_wake_arb.sv
module pmc_wake_arb
    import pmc_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    input  logic             dev_rst,
    output wake_t            wk
);
    logic [N_IRQ-1:0] irq_live;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
        assign irq_live[i] = irq_pend[i] & irq_en[i];
    end

    always_comb begin
        wk.hit   = 1'b1;
        if (dev_rst)          wk.cause = WK_RST;
        else if (wdt_timeout) wk.cause = WK_WDT;
        else if (|irq_live)   wk.cause = WK_IRQ;
        else begin
            wk.cause = WK_NONE;
            wk.hit   = 1'b0;
        end
    end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ps_req,
    input  logic             ps_mode,
    input  wake_t            wk,
    input  logic [CNT_W-1:0] startup_cycles,
    output pm_state_e        state,
    output wake_cause_e      cause,
    output logic             sleep_accept
);
    pm_state_e        state_n;
    wake_cause_e      cause_n;
    logic [CNT_W-1:0] hold_q, hold_n;
    logic             rst_wake;

    assign rst_wake = wk.hit && (wk.cause == WK_RST);

    always_comb begin
        state_n = state;
        hold_n  = hold_q;
        if (rst_wake) begin
            state_n = PM_RUN;
            hold_n  = '0;
        end else begin
            case (state)
                PM_RUN:   if (ps_req) state_n = (ps_mode == PS_IDLE) ? PM_IDLE : PM_SLEEP;
                PM_IDLE:  if (wk.hit) state_n = PM_RUN;
                PM_SLEEP: if (wk.hit) begin
                    state_n = PM_WAKE;
                    hold_n  = startup_cycles;
                end
                default: begin
                    if (hold_q == '0) state_n = PM_RUN;
                    else              hold_n  = hold_q - 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        cause_n = cause;
        if (rst_wake)
            cause_n = WK_RST;
        else if (wk.hit && (state == PM_IDLE || state == PM_SLEEP))
            cause_n = wk.cause;
    end

    assign sleep_accept = (state == PM_RUN) && ps_req && (ps_mode == PS_SLEEP) && !rst_wake;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PM_RUN;
            cause  <= WK_NONE;
            hold_q <= '0;
        end else begin
            state  <= state_n;
            cause  <= cause_n;
            hold_q <= hold_n;
        end
    end
endmodule

// File: rtl/pmc_src_reg.sv
module pmc_src_reg #(
    parameter int             SRC_W       = 3,
    parameter logic [SRC_W-1:0] DEFAULT_SRC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             force_default,
    input  logic             load_ok,
    input  logic             src_wr,
    input  logic [SRC_W-1:0] src_val,
    output logic [SRC_W-1:0] src_q
);
    always_ff @(posedge clk) begin
        if (rst || force_default) src_q <= DEFAULT_SRC;
        else if (load_ok && src_wr) src_q <= src_val;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int               N_IRQ       = 8,
    parameter int               SRC_W       = 3,
    parameter int               CNT_W       = 8,
    parameter logic [SRC_W-1:0] DEFAULT_SRC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ps_req,
    input  logic             ps_mode,
    input  logic             src_wr,
    input  logic [SRC_W-1:0] src_val,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_en,
    input  logic             wdt_timeout,
    input  logic             dev_rst,
    input  logic [CNT_W-1:0] startup_cycles,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             lprc_en,
    output logic             fscm_en,
    output logic             wdt_clr,
    output logic [SRC_W-1:0] clk_src_o,
    output logic [1:0]       wake_cause
);
    wake_t       wk;
    pm_state_e   state;
    wake_cause_e cause;
    logic        sleep_accept;
    gate_t       gates;

    pmc_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
        .irq_pend    (irq_pend),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .dev_rst     (dev_rst),
        .wk          (wk)
    );

    pmc_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .ps_req         (ps_req),
        .ps_mode        (ps_mode),
        .wk             (wk),
        .startup_cycles (startup_cycles),
        .state          (state),
        .cause          (cause),
        .sleep_accept   (sleep_accept)
    );

    pmc_src_reg #(.SRC_W(SRC_W), .DEFAULT_SRC(DEFAULT_SRC)) u_src (
        .clk           (clk),
        .rst           (rst),
        .force_default (dev_rst),
        .load_ok       (state == PM_RUN),
        .src_wr        (src_wr),
        .src_val       (src_val),
        .src_q         (clk_src_o)
    );

    assign gates      = gates_for(state, wdt_en);
    assign cpu_clk_en = gates.cpu;
    assign per_clk_en = gates.per;
    assign osc_en     = gates.osc;
    assign lprc_en    = gates.lprc;
    assign fscm_en    = gates.fscm;
    assign wdt_clr    = sleep_accept & wdt_en;
    assign wake_cause = cause;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
    parameter int               SRC_W       = 3,
    parameter logic [SRC_W-1:0] DEFAULT_SRC = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             dev_rst,
    input logic             wdt_en,
    input logic             wdt_clr,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en,
    input logic             lprc_en,
    input logic             fscm_en,
    input logic [SRC_W-1:0] clk_src_o,
    input logic [1:0]       wake_cause
);
    // R3
    sleep_gates_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (!cpu_clk_en && !per_clk_en && !fscm_en && (lprc_en == wdt_en)));

    // R4
    wdt_clr_cond_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |-> (wdt_en && cpu_clk_en));

    // R4
    wdt_clr_then_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |=> (!osc_en && !cpu_clk_en));

    // R2
    idle_gates_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && per_clk_en) |-> (osc_en && fscm_en && lprc_en));

    // R10
    rst_wake_chk: assert property (@(posedge clk) disable iff (rst)
        dev_rst |=> (cpu_clk_en && per_clk_en && clk_src_o == DEFAULT_SRC && wake_cause == 2'd3));

    // R8
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && !dev_rst) |=> (clk_src_o == $past(clk_src_o)));
endmodule

bind pwr_mode_ctrl pmc_chk #(.SRC_W(SRC_W), .DEFAULT_SRC(DEFAULT_SRC)) u_chk (.*);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
    localparam int N_IRQ = 8;
    localparam int SRC_W = 3;
    localparam int CNT_W = 8;

    localparam logic [4:0] G_RUN   = 5'b11111;
    localparam logic [4:0] G_IDLE  = 5'b01111;
    localparam logic [4:0] G_SLPW  = 5'b00010;
    localparam logic [4:0] G_SLP   = 5'b00000;
    localparam logic [4:0] G_WAKE  = 5'b00110;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ps_req = 1'b0, ps_mode = 1'b0, src_wr = 1'b0;
    logic [SRC_W-1:0] src_val = '0;
    logic [N_IRQ-1:0] irq_pend = '0, irq_en = '0;
    logic             wdt_en = 1'b0, wdt_timeout = 1'b0, dev_rst = 1'b0;
    logic [CNT_W-1:0] startup_cycles = '0;
    logic             cpu_clk_en, per_clk_en, osc_en, lprc_en, fscm_en, wdt_clr;
    logic [SRC_W-1:0] clk_src_o;
    logic [1:0]       wake_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0]       g;
        logic [SRC_W-1:0] src;
        logic [1:0]       cause;
        string            req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(N_IRQ), .SRC_W(SRC_W), .CNT_W(CNT_W), .DEFAULT_SRC(3'd0)) u_dut (
        .clk(clk), .rst(rst), .ps_req(ps_req), .ps_mode(ps_mode),
        .src_wr(src_wr), .src_val(src_val), .irq_pend(irq_pend), .irq_en(irq_en),
        .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .dev_rst(dev_rst),
        .startup_cycles(startup_cycles), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .lprc_en(lprc_en), .fscm_en(fscm_en), .wdt_clr(wdt_clr),
        .clk_src_o(clk_src_o), .wake_cause(wake_cause)
    );

    // monitor: pops one expected item per edge, samples 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                logic [4:0] g;
                e = sb.pop_front();
                g = {cpu_clk_en, per_clk_en, osc_en, lprc_en, fscm_en};
                n_chk++;
                if (g !== e.g || clk_src_o !== e.src || wake_cause !== e.cause) begin
                    n_fail++;
                    $display("FAIL %s: gates=%b src=%0d cause=%0d expected gates=%b src=%0d cause=%0d",
                             e.req, g, clk_src_o, wake_cause, e.g, e.src, e.cause);
                end
            end
        end
    end

    // driver: inputs already set after a negedge; push expected result of the next edge
    task automatic cyc(input logic [4:0] g, input logic [SRC_W-1:0] s,
                       input logic [1:0] c, input string r);
        exp_t e;
        e.g = g; e.src = s; e.cause = c; e.req = r;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_clr(input logic exp, input string r);
        #0.5;
        n_chk++;
        if (wdt_clr !== exp) begin
            n_fail++;
            $display("FAIL %s: wdt_clr=%b expected %b", r, wdt_clr, exp);
        end
    endtask

    task automatic quiet();
        ps_req = 0; src_wr = 0; irq_pend = '0; irq_en = '0;
        wdt_timeout = 0; dev_rst = 0;
    endtask

    initial begin
        @(negedge clk);
        cyc(G_RUN, 3'd0, 2'd0, "R1 in reset");
        rst = 0;
        cyc(G_RUN, 3'd0, 2'd0, "R1 after reset");

        src_wr = 1; src_val = 3'd5;
        cyc(G_RUN, 3'd5, 2'd0, "R8 write in run");
        quiet();

        // Idle entry with watchdog on: no clear pulse
        wdt_en = 1; ps_req = 1; ps_mode = 1;
        chk_clr(1'b0, "R4 idle no clear");
        cyc(G_IDLE, 3'd5, 2'd0, "R2 idle entry");
        quiet();

        irq_pend = 8'h01;
        cyc(G_IDLE, 3'd5, 2'd0, "R5 masked irq ignored");
        irq_en = 8'h01;
        cyc(G_RUN, 3'd5, 2'd1, "R6 idle wake by irq");
        quiet();

        // Sleep entry, watchdog enabled
        ps_req = 1; ps_mode = 0;
        chk_clr(1'b1, "R4 sleep clear");
        cyc(G_SLPW, 3'd5, 2'd1, "R3 sleep entry wdt on");
        quiet();

        ps_req = 1; ps_mode = 1; src_wr = 1; src_val = 3'd6;
        chk_clr(1'b0, "R4 no clear asleep");
        cyc(G_SLPW, 3'd5, 2'd1, "R9 request ignored in sleep");
        quiet();

        startup_cycles = 8'd2; wdt_timeout = 1;
        cyc(G_WAKE, 3'd5, 2'd2, "R5 wdt wake into hold");
        quiet();
        cyc(G_WAKE, 3'd5, 2'd2, "R7 hold 2");
        src_wr = 1; src_val = 3'd7;
        cyc(G_WAKE, 3'd5, 2'd2, "R7 hold 3");
        quiet();
        cyc(G_RUN, 3'd5, 2'd2, "R8 source retained after hold");

        // Sleep with watchdog off
        wdt_en = 0; ps_req = 1; ps_mode = 0;
        chk_clr(1'b0, "R4 clear gated by wdt_en");
        cyc(G_SLP, 3'd5, 2'd2, "R3 sleep entry wdt off");
        quiet();

        startup_cycles = 8'd0; irq_pend = 8'h80; irq_en = 8'h80; wdt_timeout = 1;
        cyc(G_WAKE, 3'd5, 2'd2, "R11 wdt beats irq");
        quiet();
        cyc(G_RUN, 3'd5, 2'd2, "R7 zero-length hold");

        irq_pend = 8'h10; irq_en = 8'h10; ps_req = 1; ps_mode = 0;
        cyc(G_SLP, 3'd5, 2'd2, "R3 sleep with irq pending");
        quiet();
        irq_pend = 8'h10; irq_en = 8'h10;
        cyc(G_WAKE, 3'd5, 2'd1, "R11 irq cause");
        quiet();
        cyc(G_RUN, 3'd5, 2'd1, "R7 hold done");

        src_wr = 1; src_val = 3'd4;
        cyc(G_RUN, 3'd4, 2'd1, "R8 write in run");
        quiet();
        ps_req = 1; ps_mode = 0;
        cyc(G_SLP, 3'd4, 2'd1, "R3 sleep again");
        quiet();
        dev_rst = 1; wdt_timeout = 1; irq_pend = 8'hFF; irq_en = 8'hFF; startup_cycles = 8'd5;
        cyc(G_RUN, 3'd0, 2'd3, "R10 reset wake skips hold");
        quiet();

        ps_req = 1; ps_mode = 1;
        cyc(G_IDLE, 3'd0, 2'd3, "R2 idle entry");
        quiet();
        src_wr = 1; src_val = 3'd2;
        cyc(G_IDLE, 3'd0, 2'd3, "R8 write ignored in idle");
        quiet();
        wdt_timeout = 1;
        cyc(G_RUN, 3'd0, 2'd2, "R11 wdt cause from idle");
        quiet();

        src_wr = 1; src_val = 3'd3;
        cyc(G_RUN, 3'd3, 2'd2, "R8 write in run");
        quiet();
        dev_rst = 1; src_wr = 1; src_val = 3'd6; ps_req = 1; ps_mode = 0; wdt_en = 1;
        chk_clr(1'b0, "R10 reset blocks sleep clear");
        cyc(G_RUN, 3'd0, 2'd3, "R10 reset in run");
        quiet();

        @(posedge clk); #2;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule